// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block sits between a serial receiver and the host register decode of a UART. It stores received bytes in a four-entry queue and hands them to the host oldest first. It produces a data-available flag and a queue-full flag, and it tells the receiver when it may deliver a byte. A line-break event from the receiver is stored as a zero byte and latches a sticky break-change flag. The break is never lost: when the queue is already full, the break replaces the newest stored byte.

The host pulses a read request. The oldest byte appears on the registered read-data output one cycle later. A read of an empty queue yields zero and changes nothing. A flush input empties the queue when the receiver is reset. The synchronous system reset also clears everything, including the break-change flag. The break-change flag is cleared only by its own clear pulse.

Top module: `rx_byte_queue`

## Requirements
- R1: After the synchronous reset `rst`, `avail_o`, `full_o`, `brk_flag_o` and `rd_data_o` are 0, and `rx_ready_o` equals `rx_en_i`. Reset also clears a break-change flag that is set.
- R2: Bytes leave in arrival order. A read request in cycle N puts the oldest byte on `rd_data_o` after that clock edge, and the output holds it until the next read.
- R3: Any push sets `avail_o`. `full_o` is set when the fourth byte is held, and `rx_ready_o` is then 0. The fill count never exceeds four.
- R4: A normal byte (`rx_valid_i`) is stored only when `rx_en_i` is 1 and `full_o` is 0. Otherwise the byte is dropped and the stored contents are unchanged.
- R5: A break event (`brk_evt_i`) stores the byte 0x00 and sets `brk_flag_o`. If a normal byte arrives in the same cycle, the break wins and the byte is dropped.
- R6: A break on a full queue with no read in that cycle overwrites the newest entry with 0x00. The queue stays full.
- R7: A read of a non-empty queue removes the oldest byte and clears `full_o`. `avail_o` clears when the last byte is removed.
- R8: A read of an empty queue drives 0x00 on `rd_data_o` and changes no flag.
- R9: `flush_i` empties the queue and clears `avail_o` and `full_o` after the edge, and leaves `brk_flag_o` unchanged. A read in the same cycle returns 0x00.
- R10: A push and a read in the same cycle are both honoured and the count is unchanged. A break on a full queue together with a read appends 0x00 after the oldest byte is removed.
- R11: `brk_clr_i` clears `brk_flag_o`. A break in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Receiver reset: empty the queue |
| rx_en_i | input | 1 | Receiver enabled |
| rx_valid_i | input | 1 | Received byte present this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Queue can take a normal byte |
| brk_evt_i | input | 1 | Line-break event this cycle |
| brk_clr_i | input | 1 | Clear the break-change flag |
| rd_req_i | input | 1 | Host read request |
| rd_data_o | output | 8 | Byte returned by the last read |
| avail_o | output | 1 | At least one byte held |
| full_o | output | 1 | Four bytes held |
| brk_flag_o | output | 1 | Sticky break-change flag |

## Verification
Some rules hold on every cycle, and the assertions check them there. The fill count stays within four, and full implies available. A flush leaves the queue empty, and a break always sets the flag. A clear without a break drops the flag. A read of a full queue without a break clears full, and a break on a full queue keeps it full. A read with the queue empty gives zero. With the receiver disabled and no other activity, the count does not move. Other behaviour is about data, and only the bench scenarios can show it: the order of bytes, the overwrite of the newest entry by a break, the append after a pop when a break and a read coincide, and the byte dropped when it meets a break in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    WR_IDLE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          rx_en,
  input  logic          rx_vld,
  input  logic          brk_evt,
  input  logic          rd_req,
  output wr_kind_e      wr_kind,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          pop,
  output logic [CW-1:0] count,
  output logic          avail,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          avail_q, full_q;
  logic          byte_ok, grow;

  function automatic logic [AW-1:0] step_fwd(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_back(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - AW'(1);
  endfunction

  always_comb begin
    pop     = rd_req && (cnt_q != '0) && !flush;
    byte_ok = rx_vld && rx_en && !full_q && !brk_evt && !flush;
    if (flush)        wr_kind = WR_IDLE;
    else if (brk_evt) wr_kind = (full_q && !pop) ? WR_REPLACE : WR_APPEND;
    else if (byte_ok) wr_kind = WR_APPEND;
    else              wr_kind = WR_IDLE;
    wr_addr = (wr_kind == WR_REPLACE) ? step_back(wptr_q) : wptr_q;
    rd_addr = rptr_q;
    grow    = (wr_kind == WR_APPEND);
    cnt_d   = cnt_q + (grow ? CW'(1) : '0) - (pop ? CW'(1) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      avail_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (grow) wptr_q <= step_fwd(wptr_q);
      if (pop)  rptr_q <= step_fwd(rptr_q);
      cnt_q   <= cnt_d;
      avail_q <= (cnt_d != '0);
      full_q  <= (cnt_d == CAP);
    end
  end

  assign count = cnt_q;
  assign avail = avail_q;
  assign full  = full_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_req,
  input  logic              pop,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (pop)    rd_q <= mem[raddr];
    else if (rd_req) rd_q <= '0;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/rxq_brk_flag.sv
module rxq_brk_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              rx_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              brk_evt_i,
  input  logic              brk_clr_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              avail_o,
  output logic              full_o,
  output logic              brk_flag_o
);
  wr_kind_e          wr_kind;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              pop;
  logic [CW-1:0]     fill_cnt;
  logic [DATA_W-1:0] wr_byte;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_i),
    .rx_en   (rx_en_i),
    .rx_vld  (rx_valid_i),
    .brk_evt (brk_evt_i),
    .rd_req  (rd_req_i),
    .wr_kind (wr_kind),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .pop     (pop),
    .count   (fill_cnt),
    .avail   (avail_o),
    .full    (full_o)
  );

  // a break stores an all-zero byte
  assign wr_byte = brk_evt_i ? '0 : rx_data_i;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_kind != WR_IDLE),
    .waddr   (wr_addr),
    .wdata   (wr_byte),
    .rd_req  (rd_req_i),
    .pop     (pop),
    .raddr   (rd_addr),
    .rd_data (rd_data_o)
  );

  rxq_brk_flag u_brk (
    .clk  (clk),
    .rst  (rst),
    .set  (brk_evt_i),
    .clr  (brk_clr_i),
    .flag (brk_flag_o)
  );

  assign rx_ready_o = rx_en_i && !full_o;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              flush_i,
  input logic              rx_en_i,
  input logic              rx_valid_i,
  input logic              brk_evt_i,
  input logic              brk_clr_i,
  input logic              rd_req_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              avail_o,
  input logic              full_o,
  input logic              brk_flag_o,
  input logic [CW-1:0]     fill_cnt
);
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));

  // R3
  full_avail_chk: assert property (@(posedge clk) disable iff (rst)
    full_o |-> avail_o);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!avail_o && !full_o));

  // R5
  brk_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    brk_evt_i |=> brk_flag_o);

  // R11
  brk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_clr_i && !brk_evt_i) |=> !brk_flag_o);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && !avail_o && !rx_valid_i && !brk_evt_i) |=>
      (rd_data_o == '0 && !avail_o));

  // R7
  read_unfull_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && rd_req_i && !brk_evt_i) |=> !full_o);

  // R6
  brk_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && brk_evt_i && !flush_i) |=> full_o);

  // R4
  rx_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_en_i && !brk_evt_i && !rd_req_i && !flush_i) |=> $stable(fill_cnt));
endmodule

bind rx_byte_queue rxq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush_i    (flush_i),
  .rx_en_i    (rx_en_i),
  .rx_valid_i (rx_valid_i),
  .brk_evt_i  (brk_evt_i),
  .brk_clr_i  (brk_clr_i),
  .rd_req_i   (rd_req_i),
  .rd_data_o  (rd_data_o),
  .avail_o    (avail_o),
  .full_o     (full_o),
  .brk_flag_o (brk_flag_o),
  .fill_cnt   (fill_cnt)
);

// File: tb/tb_rx_byte_queue.sv
module tb_rx_byte_queue;
  logic       clk = 1'b0;
  logic       rst;
  logic       flush_i, rx_en_i, rx_valid_i, brk_evt_i, brk_clr_i, rd_req_i;
  logic [7:0] rx_data_i;
  logic       rx_ready_o, avail_o, full_o, brk_flag_o;
  logic [7:0] rd_data_o;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  rx_byte_queue dut (
    .clk(clk), .rst(rst), .flush_i(flush_i), .rx_en_i(rx_en_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .brk_evt_i(brk_evt_i), .brk_clr_i(brk_clr_i), .rd_req_i(rd_req_i),
    .rd_data_o(rd_data_o), .avail_o(avail_o), .full_o(full_o),
    .brk_flag_o(brk_flag_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       en;
    logic       vld;
    logic [7:0] dat;
    logic       brk;
    logic       clr;
    logic       rd;
    logic       fl;
    logic       e_av;
    logic       e_fu;
    logic       e_bf;
    logic [7:0] e_rd;
  } vec_t;

  // req, en, vld, dat, brk, clr, rd, fl | avail, full, brk_flag, rd_data
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3,  1,1,8'hA1, 0,0,0,0, 1,0,0,8'h00}, // R3 first push
    '{2,  1,1,8'hA2, 0,0,0,0, 1,0,0,8'h00}, // R2
    '{2,  1,1,8'hA3, 0,0,0,0, 1,0,0,8'h00}, // R2
    '{3,  1,1,8'hA4, 0,0,0,0, 1,1,0,8'h00}, // R3 fourth byte sets full
    '{4,  1,1,8'hA5, 0,0,0,0, 1,1,0,8'h00}, // R4 dropped while full
    '{7,  1,0,8'h00, 0,0,1,0, 1,0,0,8'hA1}, // R7 read oldest clears full
    '{4,  0,1,8'hB0, 0,0,0,0, 1,0,0,8'hA1}, // R4 dropped while disabled
    '{10, 1,1,8'hA6, 0,0,1,0, 1,0,0,8'hA2}, // R10 push and pop
    '{3,  1,1,8'hA7, 0,0,0,0, 1,1,0,8'hA2}, // R3 full again
    '{6,  1,0,8'h00, 1,0,0,0, 1,1,1,8'hA2}, // R6 break replaces newest
    '{11, 1,0,8'h00, 1,1,0,0, 1,1,1,8'hA2}, // R11 break beats clear
    '{11, 1,0,8'h00, 0,1,0,0, 1,1,0,8'hA2}, // R11 clear
    '{10, 1,0,8'h00, 1,0,1,0, 1,1,1,8'hA3}, // R10 break plus read on full appends
    '{11, 1,0,8'h00, 0,1,0,0, 1,1,0,8'hA3}, // R11 clear
    '{2,  1,0,8'h00, 0,0,1,0, 1,0,0,8'hA4}, // R2
    '{2,  1,0,8'h00, 0,0,1,0, 1,0,0,8'hA6}, // R2
    '{6,  1,0,8'h00, 0,0,1,0, 1,0,0,8'h00}, // R6 A7 was replaced by zero
    '{10, 1,1,8'hB2, 0,0,1,0, 1,0,0,8'h00}, // R10 appended zero read
    '{7,  1,0,8'h00, 0,0,1,0, 0,0,0,8'hB2}, // R7 last byte clears avail
    '{8,  1,0,8'h00, 0,0,1,0, 0,0,0,8'h00}, // R8 empty read gives zero
    '{3,  1,1,8'hC1, 0,0,0,0, 1,0,0,8'h00}, // R3
    '{5,  1,1,8'hC2, 1,0,0,0, 1,0,1,8'h00}, // R5 break wins over byte
    '{9,  1,0,8'h00, 0,0,1,1, 0,0,1,8'h00}, // R9 flush with read
    '{9,  1,0,8'h00, 0,0,1,0, 0,0,1,8'h00}, // R9 nothing left after flush
    '{3,  1,1,8'hD1, 0,0,0,0, 1,0,1,8'h00}, // R3
    '{2,  1,0,8'h00, 0,0,1,0, 0,0,1,8'hD1}  // R2 order after flush
  };

  task automatic idle_inputs();
    flush_i = 0; rx_en_i = 1; rx_valid_i = 0; rx_data_i = 0;
    brk_evt_i = 0; brk_clr_i = 0; rd_req_i = 0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 reset outputs", {avail_o, full_o, brk_flag_o, rd_data_o, rx_ready_o},
          {1'b0, 1'b0, 1'b0, 8'h00, 1'b1});

    for (int i = 0; i < NV; i++) begin
      rx_en_i = VEC[i].en; rx_valid_i = VEC[i].vld; rx_data_i = VEC[i].dat;
      brk_evt_i = VEC[i].brk; brk_clr_i = VEC[i].clr;
      rd_req_i = VEC[i].rd; flush_i = VEC[i].fl;
      @(negedge clk);
      idle_inputs();
      checks++;
      if ({avail_o, full_o, brk_flag_o, rd_data_o} !==
          {VEC[i].e_av, VEC[i].e_fu, VEC[i].e_bf, VEC[i].e_rd}) begin
        errors++;
        $display("FAIL R%0d vector %0d actual av=%b fu=%b bf=%b rd=%h expected av=%b fu=%b bf=%b rd=%h",
                 VEC[i].req, i, avail_o, full_o, brk_flag_o, rd_data_o,
                 VEC[i].e_av, VEC[i].e_fu, VEC[i].e_bf, VEC[i].e_rd);
      end
    end

    // R3 ready follows enable and full
    check("R3 ready when empty", {31'd0, rx_ready_o}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      rx_valid_i = 1; rx_data_i = 8'hE0 + 8'(k);
      @(negedge clk);
      idle_inputs();
    end
    check("R3 full after four", {31'd0, full_o}, 32'd1);
    check("R3 ready low when full", {31'd0, rx_ready_o}, 32'd0);
    rx_en_i = 0;
    #1;
    check("R1 ready follows enable", {31'd0, rx_ready_o}, 32'd0);
    idle_inputs();

    // R1 mid-run reset clears data and the sticky flag
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset clears", {avail_o, full_o, brk_flag_o, rd_data_o, rx_ready_o},
          {1'b0, 1'b0, 1'b0, 8'h00, 1'b1});
    rd_req_i = 1;
    @(negedge clk);
    idle_inputs();
    check("R8 read after reset", {avail_o, rd_data_o}, {1'b0, 8'h00});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule